// File: doc/BRIEF.md
# Pipelined Instruction Address Tracker

This block sits on the coprocessor side of a host/coprocessor link. The host writes its program counter into a memory-mapped instruction-address register. The block then carries that address through three pipeline stages (bus interface, control, arithmetic) in step with the instruction it belongs to. The arithmetic-stage copy is the architecturally visible floating-point instruction address. When the arithmetic stage raises an exception, that copy is captured, so the reported address always names the faulting instruction, even after several stalls.

A small two-state machine tracks PC transfers. `PC_IDLE` means no transfer is owed. The transition `PC_IDLE -> PC_WAIT` happens when a command write arrives that needs a PC. The transition `PC_WAIT -> PC_IDLE` happens on an instruction-address write. There is also a transition `PC_WAIT -> PC_WAIT` or `PC_WAIT -> PC_IDLE` on a new command write when no address write has arrived. In that case a protocol violation is flagged for one cycle, and the next state follows whether the new command needs a PC. The operand-address register at offset 0x1C is decoded but unimplemented.

Top module: `ia_track_top`

## Requirements
- R1: A synchronous active-high reset clears all three stage address registers, the captured exception address, `pc_req` and `proto_viol` to zero.
- R2: A host write with `bus_addr` = 0x18 loads `bus_wdata` into the bus-interface stage register, and `pc_req` is low in the next cycle unless that same cycle's command write needs a PC.
- R3: `adv_ctl` copies the bus-interface stage value into the control stage, and `adv_ari` copies the control stage value into the arithmetic stage. Both copies are seen one cycle later. When a strobe is low, that stage's register holds its value.
- R4: `fpiar` always shows the arithmetic stage register.
- R5: When `exc` is high, `exc_addr` takes the value `fpiar` had in that cycle, and it is visible the next cycle. Otherwise `exc_addr` holds.
- R6: A command write (`cmd_wr`) with `cmd_need_pc` high, while no transfer is owed, sets `pc_req` in the next cycle.
- R7: A command write while `pc_req` is high, with no 0x18 write in the same cycle, drives `proto_viol` high for exactly the next cycle. `pc_req` then equals the new command's `cmd_need_pc`. If the 0x18 write does arrive in that cycle, no violation is raised.
- R8: A host read with `bus_addr` = 0x18 returns 32'hFFFF_FFFF on `bus_rdata` in the same cycle.
- R9: A read of offset 0x1C returns 32'hFFFF_FFFF. A write to 0x1C changes no stage register and raises no protocol violation.
- R10: `bus_rdata` is zero when no read is active or when a read targets any offset other than 0x18 and 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 5 | Interface register byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data |
| cmd_wr | input | 1 | New instruction accepted into the bus-interface stage |
| cmd_need_pc | input | 1 | That instruction requires a PC transfer |
| adv_ctl | input | 1 | Control stage accepts the bus-interface instruction |
| adv_ari | input | 1 | Arithmetic stage accepts the control instruction |
| exc | input | 1 | Exception strobe from the arithmetic stage |
| fpiar | output | 32 | Arithmetic-stage instruction address |
| exc_addr | output | 32 | Address captured at the last exception |
| pc_req | output | 1 | PC transfer owed by the host |
| proto_viol | output | 1 | One-cycle protocol violation pulse |

## Verification
If a stage register is loaded, dropped or shifted at the wrong time, the error stays hidden until that instruction reaches the arithmetic stage. It then shows on `fpiar` on the cycle after the matching `adv_ari`, and on `exc_addr` one cycle after the next `exc`. The bench therefore pushes every written address all the way through to an exception. A wrong handshake state shows on `pc_req` one cycle after the command or address write. It also shows on `proto_viol` one cycle after the following command write.

// File: rtl/ia_pkg.sv
package ia_pkg;
    localparam int OFS_W = 5;
    localparam logic [OFS_W-1:0] IA_OFS = 5'h18;
    localparam logic [OFS_W-1:0] OA_OFS = 5'h1C;

    typedef enum logic {
        PC_IDLE = 1'b0,
        PC_WAIT = 1'b1
    } pc_state_t;
endpackage

// File: rtl/ia_bus_decode.sv
module ia_bus_decode
    import ia_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             wr,
    input  logic             rd,
    input  logic [OFS_W-1:0] addr,
    output logic             ia_wr,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        ia_wr = wr && (addr == IA_OFS);
        rdata = '0;
        if (rd && ((addr == IA_OFS) || (addr == OA_OFS))) begin
            rdata = '1;
        end
    end
endmodule

// File: rtl/ia_req_fsm.sv
module ia_req_fsm
    import ia_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic need_pc,
    input  logic ia_wr,
    output logic pc_req,
    output logic viol
);
    pc_state_t state, state_nx;
    logic      viol_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PC_IDLE;
            viol  <= 1'b0;
        end else begin
            state <= state_nx;
            viol  <= viol_nx;
        end
    end

    always_comb begin
        state_nx = state;
        viol_nx  = 1'b0;
        unique case (state)
            PC_IDLE: begin
                if (cmd_wr && need_pc) state_nx = PC_WAIT;
            end
            PC_WAIT: begin
                if (cmd_wr) begin
                    viol_nx  = !ia_wr;
                    state_nx = need_pc ? PC_WAIT : PC_IDLE;
                end else if (ia_wr) begin
                    state_nx = PC_IDLE;
                end
            end
            default: state_nx = PC_IDLE;
        endcase
    end

    assign pc_req = (state == PC_WAIT);

    p_req_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!pc_req && cmd_wr && need_pc) |=> pc_req);
    p_req_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (pc_req && ia_wr && !cmd_wr) |=> !pc_req);
    p_viol_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (pc_req && cmd_wr && !ia_wr) |=> viol);
    p_viol_only_r7: assert property (@(posedge clk) disable iff (rst)
        !(pc_req && cmd_wr && !ia_wr) |=> !viol);
endmodule

// File: rtl/ia_stage_regs.sv
module ia_stage_regs #(
    parameter int AW  = 32,
    parameter int NST = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic [AW-1:0]  ld_val,
    input  logic [NST-2:0] adv,
    output logic [AW-1:0]  tail
);
    logic [AW-1:0] st [NST];

    always_ff @(posedge clk) begin
        if (rst)     st[0] <= '0;
        else if (ld) st[0] <= ld_val;
    end

    for (genvar i = 1; i < NST; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)           st[i] <= '0;
            else if (adv[i-1]) st[i] <= st[i-1];
        end

        p_advance_r3: assert property (@(posedge clk) disable iff (rst)
            adv[i-1] |=> (st[i] == $past(st[i-1])));
        p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !adv[i-1] |=> $stable(st[i]));
    end

    assign tail = st[NST-1];
endmodule

// File: rtl/ia_track_top.sv
module ia_track_top
    import ia_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [AW-1:0]    bus_wdata,
    output logic [AW-1:0]    bus_rdata,
    input  logic             cmd_wr,
    input  logic             cmd_need_pc,
    input  logic             adv_ctl,
    input  logic             adv_ari,
    input  logic             exc,
    output logic [AW-1:0]    fpiar,
    output logic [AW-1:0]    exc_addr,
    output logic             pc_req,
    output logic             proto_viol
);
    logic           ia_wr;
    logic [NST-2:0] adv;

    assign adv = {adv_ari, adv_ctl};

    ia_bus_decode #(.DW(AW)) u_dec (
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .ia_wr (ia_wr),
        .rdata (bus_rdata)
    );

    ia_req_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (cmd_wr),
        .need_pc (cmd_need_pc),
        .ia_wr   (ia_wr),
        .pc_req  (pc_req),
        .viol    (proto_viol)
    );

    ia_stage_regs #(.AW(AW), .NST(NST)) u_stg (
        .clk    (clk),
        .rst    (rst),
        .ld     (ia_wr),
        .ld_val (bus_wdata),
        .adv    (adv),
        .tail   (fpiar)
    );

    always_ff @(posedge clk) begin
        if (rst)      exc_addr <= '0;
        else if (exc) exc_addr <= fpiar;
    end

    p_exc_capture_r5: assert property (@(posedge clk) disable iff (rst)
        exc |=> (exc_addr == $past(fpiar)));
    p_exc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !exc |=> $stable(exc_addr));
    p_rd_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == IA_OFS) |-> (bus_rdata == '1));
    p_oa_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OA_OFS && !cmd_wr) |=> !proto_viol);
endmodule

// File: tb/tb_ia_track_top.sv
module tb_ia_track_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd, cmd_wr, cmd_need_pc, adv_ctl, adv_ari, exc;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, fpiar, exc_addr;
    logic        pc_req, proto_viol;
    int          n_chk = 0, n_fail = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    ia_track_top dut (.*);

    typedef struct packed {
        logic        wr; logic rd; logic [4:0] addr; logic [31:0] wd;
        logic        cmd; logic need; logic actl; logic aari; logic ex;
        logic [31:0] e_fp; logic [31:0] e_ex; logic e_req; logic e_viol;
        logic [31:0] e_rd;
    } vec_t;

    localparam logic [31:0] A = 32'h1000_0010, B = 32'h1000_0020,
                            C = 32'h1000_0030, D = 32'h1000_0040, ONES = 32'hFFFF_FFFF;
    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{0,0,5'h00,0, 1,1,0,0,0, 0,0,1,0, 0},      // R6 request set
        '{1,0,5'h18,A, 0,0,0,0,0, 0,0,0,0, 0},      // R2 load bus stage, clear
        '{0,0,5'h00,0, 0,0,1,0,0, 0,0,0,0, 0},      // R3 bus->ctl (A)
        '{0,0,5'h00,0, 1,1,0,0,0, 0,0,1,0, 0},      // R6
        '{1,0,5'h18,B, 0,0,0,1,0, A,0,0,0, 0},      // R2 R3 R4 ctl->ari (A)
        '{0,1,5'h18,0, 0,0,0,0,0, A,0,0,0, ONES},   // R8 read ones, R3 stall
        '{0,0,5'h00,0, 0,0,1,0,0, A,0,0,0, 0},      // R3 ctl=B
        '{0,0,5'h00,0, 0,0,0,0,1, A,A,0,0, 0},      // R5 capture A
        '{1,0,5'h1C,C, 0,0,0,0,0, A,A,0,0, 0},      // R9 write ignored
        '{0,1,5'h1C,0, 0,0,1,0,0, A,A,0,0, ONES},   // R9 read ones, ctl<=bus(B)
        '{0,0,5'h00,0, 0,0,0,1,0, B,A,0,0, 0},      // R3 R9 B proves OA write dropped
        '{0,0,5'h00,0, 0,0,0,0,1, B,B,0,0, 0},      // R5 capture B
        '{0,0,5'h00,0, 1,1,0,0,0, B,B,1,0, 0},      // R6
        '{0,0,5'h00,0, 1,1,0,0,0, B,B,1,1, 0},      // R7 skipped PC
        '{0,0,5'h00,0, 0,0,0,0,0, B,B,1,0, 0},      // R7 one-cycle pulse
        '{1,0,5'h18,D, 1,0,0,0,0, B,B,0,0, 0},      // R7 PC with command: no viol
        '{0,1,5'h04,0, 0,0,0,0,0, B,B,0,0, 0},      // R10 other offset reads 0
        '{0,0,5'h00,0, 0,0,1,1,0, B,B,0,0, 0},      // R3 both advance
        '{0,0,5'h00,0, 0,0,0,1,0, D,B,0,0, 0},      // R3 R4 D reaches ari
        '{0,0,5'h00,0, 0,0,0,0,1, D,D,0,0, 0}       // R5 capture D
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        cmd_wr = 0; cmd_need_pc = 0; adv_ctl = 0; adv_ari = 0; exc = 0;
    endtask

    task automatic chk_reset(input string when);
        chk({"R1 fpiar ", when}, fpiar, 32'h0);
        chk({"R1 exc_addr ", when}, exc_addr, 32'h0);
        chk({"R1 pc_req ", when}, {31'b0, pc_req}, 32'h0);
        chk({"R1 proto_viol ", when}, {31'b0, proto_viol}, 32'h0);
    endtask

    initial begin
        idle_in();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_reset("initial");
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            bus_wr = TBL[i].wr; bus_rd = TBL[i].rd; bus_addr = TBL[i].addr;
            bus_wdata = TBL[i].wd; cmd_wr = TBL[i].cmd; cmd_need_pc = TBL[i].need;
            adv_ctl = TBL[i].actl; adv_ari = TBL[i].aari; exc = TBL[i].ex;
            @(negedge clk);
            chk($sformatf("R3/R4 fpiar row %0d", i), fpiar, TBL[i].e_fp);
            chk($sformatf("R5 exc_addr row %0d", i), exc_addr, TBL[i].e_ex);
            chk($sformatf("R6 pc_req row %0d", i), {31'b0, pc_req}, {31'b0, TBL[i].e_req});
            chk($sformatf("R7 proto_viol row %0d", i), {31'b0, proto_viol}, {31'b0, TBL[i].e_viol});
            chk($sformatf("R8/R10 bus_rdata row %0d", i), bus_rdata, TBL[i].e_rd);
        end
        // Directed: operand-address write while a PC is owed raises no violation (R9)
        idle_in(); cmd_wr = 1; cmd_need_pc = 1;
        @(negedge clk);
        idle_in(); bus_wr = 1; bus_addr = 5'h1C; bus_wdata = A;
        @(negedge clk);
        chk("R9 no viol on OA write", {31'b0, proto_viol}, 32'h0);
        chk("R9 pc_req kept", {31'b0, pc_req}, 32'h1);
        // Directed: mid-operation reset clears everything (R1)
        idle_in(); rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_reset("mid-run");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule